// File: doc/BRIEF.md
# Wake-Pin Interrupt Controller

This block watches a small set of external wake pins and a few always-on peripheral sources. It turns their activity into three outputs: one combined interrupt for the wake pins, one routed interrupt line per peripheral source, and a single wake request for the power controller. Each wake pin has its own trigger mode. The modes are level low, level high, falling edge, rising edge, any change, or never. Each pin also has a control bit that holds its pending flag clear.

Software talks to the block through a plain 32-bit register port. The port has a write strobe, a byte address and write data, and read data is returned combinationally for the current address. A triggered pin latches a sticky pending bit. That bit counts toward the combined interrupt only when both its enable bit and its interrupt-routing bit are set. A separate wake-routing bit decides whether the same pending bit may raise the wake request. Peripheral inputs are not latched: they pass straight through to their outputs when routed.

Top module: `wake_irq_ctrl`

## Requirements
- R1: While reset is asserted, every register reads zero and `pin_irq`, `periph_irq` and `wake_req` are low.
- R2: The register map is as follows. The pending bits are at 0x310 and are read-only. The enable mask is at 0x314 and keeps bits N_PINS-1:0. The acknowledge register is at 0x318 and always reads 0. The routing word is at 0x31C and keeps only its defined bits. For pin n, the configuration word is at 0x330+8n and a free 32-bit scratch word is at 0x334+8n. Unmapped addresses read 0.
- R3: Bit 0 of a pin's configuration word shows the pin level after a two-flop synchronizer. The read value follows an input change on the second rising clock edge.
- R4: Bits 3:1 of the configuration word select the trigger. The codes are 0 = level low, 1 = level high, 2 = falling edge, 3 = rising edge and 6 = either edge. Codes 4, 5 and 7 never set the pending bit. A pending bit sets on the third rising edge after the pin change that satisfies its trigger.
- R5: Writing 1 to bit n of 0x318 clears pending bit n. A clear takes priority over a trigger in the same cycle. If the level condition still holds, a level-mode pin sets again on the following edge.
- R6: `pin_irq` is high exactly when some pin n has its pending bit, enable bit n and routing bit 8+n all set.
- R7: `wake_req` is the OR of two groups of terms. The first is each pending bit n whose routing bit 24+n is set. The second is each `periph_in[k]` whose routing bit 16+k is set.
- R8: `periph_irq[k]` equals `periph_in[k]` AND routing bit k.
- R9: While bit 4 of a pin's configuration word is 1, that pin's pending bit is held at 0. Once the bit returns to 0, the pin triggers normally again.
- R10: Writes to the pending-bit address 0x310 do not change the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | N_PINS | Asynchronous wake pins |
| periph_in | input | N_PERIPH | Peripheral wake sources, synchronous |
| pin_irq | output | 1 | Combined wake-pin interrupt |
| periph_irq | output | N_PERIPH | Routed peripheral interrupts |
| wake_req | output | 1 | Wake request |

## Verification
The assertions assume that `periph_in` is already synchronous to `clk`. They also assume that bus writes do not overlap reset release, so pending bits can only rise from triggers sampled after reset. The bench drives every input on the falling edge and holds each pin level for several cycles around a mode change. As a result, no edge lands in the same cycle as a configuration or acknowledge write unless a test places it there on purpose. The synchronizer check only fires once two clocks have passed since reset, so that pre-reset pin values never count.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 12'h310;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h314;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 12'h318;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 12'h31C;
  localparam logic [ADDR_W-1:0] OFS_PCFG  = 12'h330;
  localparam int PCFG_STEP = 8;

  localparam int RT_PER_IRQ  = 0;
  localparam int RT_PIN_IRQ  = 8;
  localparam int RT_PER_WAKE = 16;
  localparam int RT_PIN_WAKE = 24;

  typedef enum logic [2:0] {
    TRG_LOW  = 3'd0,
    TRG_HIGH = 3'd1,
    TRG_FALL = 3'd2,
    TRG_RISE = 3'd3,
    TRG_OFF  = 3'd4,
    TRG_ANY  = 3'd6
  } trg_mode_e;

  function automatic logic trg_hit(input logic [2:0] mode, input logic cur, input logic prev);
    case (mode)
      TRG_LOW:  return !cur;
      TRG_HIGH: return cur;
      TRG_FALL: return prev && !cur;
      TRG_RISE: return cur && !prev;
      TRG_ANY:  return cur != prev;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic trg_quiet(input logic [2:0] mode);
    return (mode == 3'd4) || (mode == 3'd5) || (mode == 3'd7);
  endfunction

  function automatic logic [ADDR_W-1:0] pcfg_addr(input int n);
    return OFS_PCFG + ADDR_W'(PCFG_STEP * n);
  endfunction

  function automatic logic [DATA_W-1:0] route_mask(input int npins, input int nper);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < npins; i++) begin
      m[RT_PIN_IRQ + i]  = 1'b1;
      m[RT_PIN_WAKE + i] = 1'b1;
    end
    for (int k = 0; k < nper; k++) begin
      m[RT_PER_IRQ + k]  = 1'b1;
      m[RT_PER_WAKE + k] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl_q    <= '0;
      lvl_prev <= '0;
      age_q    <= '0;
    end else begin
      meta_q   <= d_in;
      lvl_q    <= meta_q;
      lvl_prev <= lvl_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  a_r3_two_flop: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (lvl_q == $past(d_in, 2)));
endmodule

// File: rtl/wk_trigger.sv
module wk_trigger
  import wk_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0][2:0] mode,
  input  logic [N-1:0]      cur,
  input  logic [N-1:0]      prev,
  output logic [N-1:0]      hit,
  output logic [N-1:0]      quiet
);
  for (genvar n = 0; n < N; n++) begin : g_pin
    assign hit[n]   = trg_hit(mode[n], cur[n], prev[n]);
    assign quiet[n] = trg_quiet(mode[n]);
  end
endmodule

// File: rtl/wk_route.sv
module wk_route
  import wk_pkg::*;
#(
  parameter int N_PINS   = 4,
  parameter int N_PERIPH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PINS-1:0]   pend,
  input  logic [N_PINS-1:0]   mask,
  input  logic [DATA_W-1:0]   route,
  input  logic [N_PERIPH-1:0] periph_in,
  output logic                pin_irq,
  output logic [N_PERIPH-1:0] periph_irq,
  output logic                wake_req
);
  logic [N_PINS-1:0]   pin_irq_en, pin_wake_en;
  logic [N_PERIPH-1:0] per_irq_en, per_wake_en;

  assign pin_irq_en  = route[RT_PIN_IRQ  +: N_PINS];
  assign pin_wake_en = route[RT_PIN_WAKE +: N_PINS];
  assign per_irq_en  = route[RT_PER_IRQ  +: N_PERIPH];
  assign per_wake_en = route[RT_PER_WAKE +: N_PERIPH];

  assign pin_irq    = |(pend & mask & pin_irq_en);
  assign periph_irq = periph_in & per_irq_en;
  assign wake_req   = |(pend & pin_wake_en) | |(periph_in & per_wake_en);

  a_r6_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    pin_irq |-> ((pend & mask) != '0));
  a_r7_wake_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_wake_en == '0) && (per_wake_en == '0)) |-> !wake_req);
  a_r8_periph_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_irq & ~per_irq_en) == '0);
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wk_pkg::*;
#(
  parameter int N_PINS   = 4,
  parameter int N_PERIPH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [N_PINS-1:0]   pin_in,
  input  logic [N_PERIPH-1:0] periph_in,
  output logic                pin_irq,
  output logic [N_PERIPH-1:0] periph_irq,
  output logic                wake_req
);
  localparam logic [DATA_W-1:0] ROUTE_KEEP = route_mask(N_PINS, N_PERIPH);

  logic [N_PINS-1:0]        pend_q, mask_q, hold_q;
  logic [N_PINS-1:0][2:0]   mode_q;
  logic [N_PINS-1:0][31:0]  aux_q;
  logic [DATA_W-1:0]        route_q;
  logic [N_PINS-1:0]        lvl_q, lvl_prev, hit, quiet;
  logic [N_PINS-1:0]        pend_d, ack_bits;
  logic                     ack_wr;

  wk_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .lvl_q(lvl_q), .lvl_prev(lvl_prev)
  );

  wk_trigger #(.N(N_PINS)) u_trig (
    .mode(mode_q), .cur(lvl_q), .prev(lvl_prev), .hit(hit), .quiet(quiet)
  );

  wk_route #(.N_PINS(N_PINS), .N_PERIPH(N_PERIPH)) u_route (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(mask_q), .route(route_q),
    .periph_in(periph_in), .pin_irq(pin_irq), .periph_irq(periph_irq),
    .wake_req(wake_req)
  );

  assign ack_wr   = bus_wr_en && (bus_addr == OFS_ACK);
  assign ack_bits = ack_wr ? bus_wdata[N_PINS-1:0] : '0;

  // acknowledge beats a same-cycle trigger; the hold bit beats both
  always_comb begin
    pend_d = (pend_q | hit) & ~ack_bits & ~hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '0;
      hold_q  <= '0;
      mode_q  <= '0;
      aux_q   <= '0;
      route_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (bus_wr_en) begin
        if (bus_addr == OFS_MASK)  mask_q  <= bus_wdata[N_PINS-1:0];
        if (bus_addr == OFS_ROUTE) route_q <= bus_wdata & ROUTE_KEEP;
        for (int n = 0; n < N_PINS; n++) begin
          if (bus_addr == pcfg_addr(n)) begin
            mode_q[n] <= bus_wdata[3:1];
            hold_q[n] <= bus_wdata[4];
          end
          if (bus_addr == pcfg_addr(n) + 12'd4) aux_q[n] <= bus_wdata;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_PEND:  bus_rdata[N_PINS-1:0] = pend_q;
      OFS_MASK:  bus_rdata[N_PINS-1:0] = mask_q;
      OFS_ROUTE: bus_rdata = route_q;
      default:   ;
    endcase
    for (int n = 0; n < N_PINS; n++) begin
      if (bus_addr == pcfg_addr(n))
        bus_rdata = {27'd0, hold_q[n], mode_q[n], lvl_q[n]};
      if (bus_addr == pcfg_addr(n) + 12'd4)
        bus_rdata = aux_q[n];
    end
  end

  a_r4_quiet_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & $past(quiet)) == '0);
  a_r5_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((pend_q & $past(bus_wdata[N_PINS-1:0])) == '0));
  a_r9_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(hold_q)) == '0);
  a_r10_pend_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && (bus_addr == OFS_PEND) && (hold_q == '0)) |=>
      (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: tb/sim_wake_irq_ctrl.sv
module sim_wake_irq_ctrl;
  localparam int NP = 4;
  localparam int NK = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NK-1:0] periph_in = '0;
  logic          pin_irq, wake_req;
  logic [NK-1:0] periph_irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wake_irq_ctrl #(.N_PINS(NP), .N_PERIPH(NK)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .periph_in(periph_in), .pin_irq(pin_irq), .periph_irq(periph_irq),
    .wake_req(wake_req)
  );

  // each entry: {mode[2:0], level before, level after, expected pending}
  localparam logic [5:0] VEC [14] = '{
    {3'd0, 1'b1, 1'b0, 1'b1}, {3'd0, 1'b1, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b1}, {3'd1, 1'b0, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b0, 1'b1}, {3'd2, 1'b0, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b1, 1'b1}, {3'd3, 1'b1, 1'b0, 1'b0},
    {3'd6, 1'b0, 1'b1, 1'b1}, {3'd6, 1'b1, 1'b0, 1'b1},
    {3'd6, 1'b1, 1'b1, 1'b0}, {3'd4, 1'b0, 1'b1, 1'b0},
    {3'd5, 1'b1, 1'b0, 1'b0}, {3'd7, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    // R1 reset state, sampled while reset is held
    idle(2);
    rd(12'h310, v); chk("R1 pending", v, 0);
    rd(12'h314, v); chk("R1 mask", v, 0);
    rd(12'h31C, v); chk("R1 route", v, 0);
    rd(12'h330, v); chk("R1 pin0 cfg", v, 0);
    chk("R1 outputs", {29'd0, pin_irq, wake_req, |periph_irq}, 0);
    rst_n = 1'b1;
    // park all pins in never mode
    for (int n = 0; n < NP; n++) wr(12'h330 + 12'(8*n), 32'h8);
    wr(12'h318, 32'hF);

    // R2 register map
    wr(12'h314, 32'hFFFF_FFFF); rd(12'h314, v); chk("R2 mask width", v, 32'hF);
    wr(12'h314, 32'h0);
    wr(12'h31C, 32'hFFFF_FFFF); rd(12'h31C, v); chk("R2 route keep", v, 32'h0F07_0F07);
    wr(12'h31C, 32'h0);
    wr(12'h33C, 32'hA5A5_1234); rd(12'h33C, v); chk("R2 scratch", v, 32'hA5A5_1234);
    rd(12'h318, v); chk("R2 ack reads 0", v, 0);
    rd(12'h300, v); chk("R2 unmapped", v, 0);
    rd(12'h340, v); chk("R2 pin2 cfg fields", v, 32'h8);

    // R3 synchronizer latency on pin 2
    @(negedge clk); pin_in[2] = 1'b1;
    @(negedge clk); rd(12'h340, v); chk("R3 after one edge", v[0], 0);
    @(negedge clk); rd(12'h340, v); chk("R3 after two edges", v[0], 1);
    pin_in[2] = 1'b0;

    // R4 trigger modes through the vector table, pin 0
    foreach (VEC[i]) begin
      wr(12'h330, 32'h8);
      pin_in[0] = VEC[i][2];
      idle(4);
      wr(12'h330, {28'd0, VEC[i][5:3], 1'b0});
      wr(12'h318, 32'h1);
      pin_in[0] = VEC[i][1];
      idle(5);
      rd(12'h310, v);
      chk($sformatf("R4 mode %0d %b->%b", VEC[i][5:3], VEC[i][2], VEC[i][1]), v[0], VEC[i][0]);
    end

    // R4 latency: rising edge sets on the third edge
    wr(12'h330, 32'h8); pin_in[0] = 1'b0; idle(4);
    wr(12'h330, 32'h6); wr(12'h318, 32'h1);
    pin_in[0] = 1'b1;
    idle(2); rd(12'h310, v); chk("R4 not before third edge", v[0], 0);
    idle(1); rd(12'h310, v); chk("R4 on third edge", v[0], 1);

    // R5 level high re-asserts after acknowledge
    wr(12'h330, 32'h2); idle(3);
    wr(12'h318, 32'h1); rd(12'h310, v); chk("R5 cleared", v[0], 0);
    idle(1); rd(12'h310, v); chk("R5 level re-sets", v[0], 1);
    // R5 edge mode stays clear after acknowledge
    wr(12'h330, 32'h6); wr(12'h318, 32'h1); idle(3);
    rd(12'h310, v); chk("R5 edge stays clear", v[0], 0);

    // R10 write to pending address ignored
    wr(12'h330, 32'h2); idle(2);
    wr(12'h310, 32'h0); rd(12'h310, v); chk("R10 pending kept", v[0], 1);

    // R6 combined interrupt needs mask and routing
    wr(12'h314, 32'h1); idle(1); chk("R6 mask only", pin_irq, 0);
    wr(12'h31C, 32'h100); idle(1); chk("R6 mask and route", pin_irq, 1);
    wr(12'h314, 32'h0); idle(1); chk("R6 route only", pin_irq, 0);

    // R7 wake request
    wr(12'h31C, 32'h0100_0000); idle(1); chk("R7 pin wake", wake_req, 1);
    wr(12'h31C, 32'h0); idle(1); chk("R7 no wake route", wake_req, 0);
    periph_in = 3'b010;
    wr(12'h31C, 32'h0002_0000); idle(1); chk("R7 periph wake", wake_req, 1);
    wr(12'h31C, 32'h0001_0000); idle(1); chk("R7 other periph wake", wake_req, 0);

    // R8 peripheral pass-through
    periph_in = 3'b101;
    wr(12'h31C, 32'h1); idle(1); chk("R8 routed subset", {29'd0, periph_irq}, 32'h1);
    wr(12'h31C, 32'h7); idle(1); chk("R8 all routed", {29'd0, periph_irq}, 32'h5);
    periph_in = 3'b000; wr(12'h31C, 32'h0);

    // R9 hold bit keeps pending clear
    wr(12'h330, 32'h12); idle(3);
    rd(12'h310, v); chk("R9 held", v[0], 0);
    wr(12'h330, 32'h2); idle(2);
    rd(12'h310, v); chk("R9 released", v[0], 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule